// File: doc/BRIEF.md
# Multiplexed Queue Flag Status Bus

This block reports the almost-full and almost-empty flags of up to 32 queues over two narrow status busses. A receiver can therefore watch queues that are not currently selected on either data port. The queues are grouped into status words of `BUS_W` queues each. Status word `w` (counted from 0) carries queues `w*BUS_W` through `w*BUS_W + BUS_W - 1`, with the lowest-numbered queue on bit 0. With the default parameters there are four status words of eight queues.

The almost-full bus runs on the write clock and takes its word address from the write side. The almost-empty bus runs on the read clock and takes its word address from the read side. A single mode input sets both busses to polled or direct operation:

- **Polled:** each bus steps to the next status word on every edge of its own clock and wraps after the last word.
- **Direct:** each bus shows the word last loaded through its own address strobe.

A word index output travels with each bus, so the receiver knows which queues the eight bits describe. Bits for queues at or above the configured queue count are driven to zero. The threshold comparisons that produce the per-queue flags are done elsewhere; this block only carries their results.

Top module: `mq_flag_status_bus`

## Requirements
- R1: While a side's active-low reset is asserted, that side's word index is 0 and its bus is all zeros.
- R2: After each clock edge of a side, bus bit j equals the flag input of queue `word*8 + j`, as sampled at that same edge, where `word` is the index shown after the edge. Queue q's flag is bit q of the flag input.
- R3: In polled mode (`direct_mode` = 0), the word index advances by one on every edge of the side's own clock and wraps from 3 to 0. Address strobes have no effect on the index in this mode.
- R4: In direct mode (`direct_mode` = 1), an edge with the side's address strobe high loads the word index from that side's address input.
- R5: In direct mode, an edge without a strobe keeps the word index unchanged. The bus still refreshes from the current flags of that word.
- R6: The two sides are addressed independently. A strobe on one side never changes the other side's word index.
- R7: A bus bit whose queue number is at or above `queue_count` is driven to 0. Polling still visits all four words even when `queue_count` is 8 or less.
- R8: When the mode changes from direct to polled, polling resumes from the word that was being shown. The next index is that word plus one, with wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock, drives the almost-full bus |
| wr_rst_n | input | 1 | Asynchronous active-low reset, write side |
| rd_clk | input | 1 | Read-side clock, drives the almost-empty bus |
| rd_rst_n | input | 1 | Asynchronous active-low reset, read side |
| direct_mode | input | 1 | 0 selects polled mode, 1 selects direct mode, for both busses |
| queue_count | input | 6 | Number of configured queues, 1 to 32 |
| af_flags | input | 32 | Almost-full flag of each queue, bit q for queue q |
| af_addr | input | 2 | Status word to show on the almost-full bus in direct mode |
| af_addr_stb | input | 1 | Loads `af_addr` on the next write clock edge in direct mode |
| ae_flags | input | 32 | Almost-empty flag of each queue, bit q for queue q |
| ae_addr | input | 2 | Status word to show on the almost-empty bus in direct mode |
| ae_addr_stb | input | 1 | Loads `ae_addr` on the next read clock edge in direct mode |
| af_bus | output | 8 | Almost-full status word currently shown |
| af_word | output | 2 | Index of the word on `af_bus` |
| ae_bus | output | 8 | Almost-empty status word currently shown |
| ae_word | output | 2 | Index of the word on `ae_bus` |

## Verification
Two events can land on the same edge: an address strobe that moves a bus to a new word, and a change in the flags feeding that bus. The result must show the new word's flags as sampled at that edge, not stale data from the old word.

The bench provokes this by drawing fresh random flags on every cycle alongside random strobes and addresses. It also flips the mode in the same cycle as a pending strobe. Each bus and index is judged against a model that first picks the word from the mode, strobe and address, and then slices and masks the flags sampled at that edge.

// File: rtl/mqfs_pkg.sv
package mqfs_pkg;

   typedef enum logic {
      MQFS_POLLED = 1'b0,
      MQFS_DIRECT = 1'b1
   } mqfs_mode_e;

   // number of status words needed for nq queues on a bw-bit bus
   function automatic int unsigned mqfs_words(input int unsigned nq, input int unsigned bw);
      return (nq + bw - 1) / bw;
   endfunction

   // index width, never below one bit
   function automatic int unsigned mqfs_bits(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/mqfs_word_seq.sv
module mqfs_word_seq #(
   parameter int unsigned NUM_W = 4,
   parameter int unsigned IDX_W = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  mqfs_pkg::mqfs_mode_e   mode,
   input  logic [IDX_W-1:0]       addr,
   input  logic                   addr_stb,
   output logic [IDX_W-1:0]       word_q,
   output logic [IDX_W-1:0]       word_nxt
);

   logic             addr_ok;
   logic [IDX_W-1:0] word_inc;

   // every address code is a real word only when NUM_W fills the index range
   generate
      if (NUM_W == (1 << IDX_W)) begin : g_full_range
         assign addr_ok = 1'b1;
      end else begin : g_part_range
         assign addr_ok = (int'(addr) < int'(NUM_W));
      end
   endgenerate

   assign word_inc = (int'(word_q) == int'(NUM_W) - 1) ? '0 : word_q + 1'b1;

   always_comb begin
      case (mode)
         mqfs_pkg::MQFS_DIRECT: word_nxt = (addr_stb && addr_ok) ? addr : word_q;
         default:               word_nxt = word_inc;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else        word_q <= word_nxt;
   end

endmodule

// File: rtl/mqfs_word_mask.sv
module mqfs_word_mask #(
   parameter int unsigned NUM_Q = 32,
   parameter int unsigned BUS_W = 8,
   parameter int unsigned NUM_W = 4,
   parameter int unsigned IDX_W = 2,
   parameter int unsigned CNT_W = 6
) (
   input  logic [NUM_Q-1:0] flags,
   input  logic [IDX_W-1:0] word,
   input  logic [CNT_W-1:0] qcount,
   output logic [BUS_W-1:0] slice
);

   localparam int unsigned PAD_W = NUM_W * BUS_W;

   logic [PAD_W-1:0] padded;
   logic [BUS_W-1:0] raw;

   // the last word may be partial: extend the flag vector with zeros
   generate
      if (PAD_W > NUM_Q) begin : g_pad
         assign padded = {{(PAD_W - NUM_Q){1'b0}}, flags};
      end else begin : g_nopad
         assign padded = flags;
      end
   endgenerate

   assign raw = padded[int'(word) * int'(BUS_W) +: BUS_W];

   // bits for unconfigured queues are forced low
   generate
      for (genvar j = 0; j < int'(BUS_W); j++) begin : g_bit
         assign slice[j] = raw[j] & ((int'(word) * int'(BUS_W) + j) < int'(qcount));
      end
   endgenerate

endmodule

// File: rtl/mqfs_side.sv
module mqfs_side #(
   parameter int unsigned NUM_Q = 32,
   parameter int unsigned BUS_W = 8,
   parameter int unsigned NUM_W = 4,
   parameter int unsigned IDX_W = 2,
   parameter int unsigned CNT_W = 6
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  mqfs_pkg::mqfs_mode_e  mode,
   input  logic [CNT_W-1:0]      qcount,
   input  logic [NUM_Q-1:0]      flags,
   input  logic [IDX_W-1:0]      addr,
   input  logic                  addr_stb,
   output logic [BUS_W-1:0]      bus,
   output logic [IDX_W-1:0]      word
);

   logic [IDX_W-1:0] word_nxt;
   logic [BUS_W-1:0] slice;
   logic [BUS_W-1:0] bus_q;

   mqfs_word_seq #(
      .NUM_W (NUM_W),
      .IDX_W (IDX_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode),
      .addr     (addr),
      .addr_stb (addr_stb),
      .word_q   (word),
      .word_nxt (word_nxt)
   );

   // slice taken on the word that becomes visible at this edge
   mqfs_word_mask #(
      .NUM_Q (NUM_Q),
      .BUS_W (BUS_W),
      .NUM_W (NUM_W),
      .IDX_W (IDX_W),
      .CNT_W (CNT_W)
   ) u_mask (
      .flags  (flags),
      .word   (word_nxt),
      .qcount (qcount),
      .slice  (slice)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_q <= '0;
      else        bus_q <= slice;
   end

   assign bus = bus_q;

endmodule

// File: rtl/mq_flag_status_bus.sv
module mq_flag_status_bus #(
   parameter  int unsigned NUM_Q = 32,
   parameter  int unsigned BUS_W = 8,
   localparam int unsigned NUM_W = mqfs_pkg::mqfs_words(NUM_Q, BUS_W),
   localparam int unsigned IDX_W = mqfs_pkg::mqfs_bits(NUM_W),
   localparam int unsigned CNT_W = $clog2(NUM_Q + 1)
) (
   input  logic             wr_clk,
   input  logic             wr_rst_n,
   input  logic             rd_clk,
   input  logic             rd_rst_n,
   input  logic             direct_mode,
   input  logic [CNT_W-1:0] queue_count,
   input  logic [NUM_Q-1:0] af_flags,
   input  logic [IDX_W-1:0] af_addr,
   input  logic             af_addr_stb,
   input  logic [NUM_Q-1:0] ae_flags,
   input  logic [IDX_W-1:0] ae_addr,
   input  logic             ae_addr_stb,
   output logic [BUS_W-1:0] af_bus,
   output logic [IDX_W-1:0] af_word,
   output logic [BUS_W-1:0] ae_bus,
   output logic [IDX_W-1:0] ae_word
);

   localparam int unsigned SIDES = 2;

   generate
      if (NUM_Q < 1) begin : g_err_nq
         $error("mq_flag_status_bus: NUM_Q must be at least 1");
      end
      if (BUS_W < 1) begin : g_err_bw
         $error("mq_flag_status_bus: BUS_W must be at least 1");
      end
      if (NUM_W * BUS_W > 4096) begin : g_err_size
         $error("mq_flag_status_bus: padded flag vector too wide");
      end
   endgenerate

   mqfs_pkg::mqfs_mode_e mode;
   assign mode = direct_mode ? mqfs_pkg::MQFS_DIRECT : mqfs_pkg::MQFS_POLLED;

   // side 0 = almost-full on the write clock, side 1 = almost-empty on the read clock
   logic [SIDES-1:0] clk_v;
   logic [SIDES-1:0] rst_v;
   logic [SIDES-1:0] stb_v;
   logic [NUM_Q-1:0] flags_v [SIDES];
   logic [IDX_W-1:0] addr_v  [SIDES];
   logic [IDX_W-1:0] word_v  [SIDES];
   logic [BUS_W-1:0] bus_v   [SIDES];

   assign clk_v      = {rd_clk, wr_clk};
   assign rst_v      = {rd_rst_n, wr_rst_n};
   assign stb_v      = {ae_addr_stb, af_addr_stb};
   assign flags_v[0] = af_flags;
   assign flags_v[1] = ae_flags;
   assign addr_v[0]  = af_addr;
   assign addr_v[1]  = ae_addr;

   generate
      for (genvar s = 0; s < int'(SIDES); s++) begin : g_side
         mqfs_side #(
            .NUM_Q (NUM_Q),
            .BUS_W (BUS_W),
            .NUM_W (NUM_W),
            .IDX_W (IDX_W),
            .CNT_W (CNT_W)
         ) u_side (
            .clk      (clk_v[s]),
            .rst_n    (rst_v[s]),
            .mode     (mode),
            .qcount   (queue_count),
            .flags    (flags_v[s]),
            .addr     (addr_v[s]),
            .addr_stb (stb_v[s]),
            .bus      (bus_v[s]),
            .word     (word_v[s])
         );
      end
   endgenerate

   assign af_bus  = bus_v[0];
   assign af_word = word_v[0];
   assign ae_bus  = bus_v[1];
   assign ae_word = word_v[1];

endmodule

// File: rtl/mqfs_chk.sv
module mqfs_chk #(
   parameter  int unsigned NUM_Q = 32,
   parameter  int unsigned BUS_W = 8,
   localparam int unsigned NUM_W = mqfs_pkg::mqfs_words(NUM_Q, BUS_W),
   localparam int unsigned IDX_W = mqfs_pkg::mqfs_bits(NUM_W),
   localparam int unsigned CNT_W = $clog2(NUM_Q + 1)
) (
   input logic             wr_clk,
   input logic             wr_rst_n,
   input logic             rd_clk,
   input logic             rd_rst_n,
   input logic             direct_mode,
   input logic [CNT_W-1:0] queue_count,
   input logic [IDX_W-1:0] af_addr,
   input logic             af_addr_stb,
   input logic [IDX_W-1:0] ae_addr,
   input logic             ae_addr_stb,
   input logic [BUS_W-1:0] af_bus,
   input logic [IDX_W-1:0] af_word,
   input logic [BUS_W-1:0] ae_bus,
   input logic [IDX_W-1:0] ae_word
);

   function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] w);
      return (int'(w) == int'(NUM_W) - 1) ? '0 : w + 1'b1;
   endfunction

   function automatic logic pad_clear(input logic [BUS_W-1:0] b,
                                      input logic [IDX_W-1:0] w,
                                      input logic [CNT_W-1:0] qc);
      logic ok;
      ok = 1'b1;
      for (int j = 0; j < int'(BUS_W); j++)
         if ((int'(w) * int'(BUS_W) + j) >= int'(qc) && b[j]) ok = 1'b0;
      return ok;
   endfunction

   p_af_reset_r1: assert property (@(posedge wr_clk)
      !wr_rst_n |-> (af_word == '0 && af_bus == '0));
   p_ae_reset_r1: assert property (@(posedge rd_clk)
      !rd_rst_n |-> (ae_word == '0 && ae_bus == '0));

   p_af_poll_r3: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      !direct_mode |=> (af_word == step($past(af_word))));
   p_ae_poll_r3: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      !direct_mode |=> (ae_word == step($past(ae_word))));

   p_af_load_r4: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      (direct_mode && af_addr_stb) |=> (af_word == $past(af_addr)));
   p_ae_load_r4: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      (direct_mode && ae_addr_stb) |=> (ae_word == $past(ae_addr)));

   p_af_hold_r5: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      (direct_mode && !af_addr_stb) |=> $stable(af_word));
   p_ae_hold_r5: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      (direct_mode && !ae_addr_stb) |=> $stable(ae_word));

   p_af_pad_r7: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      $stable(queue_count) |-> pad_clear(af_bus, af_word, queue_count));
   p_ae_pad_r7: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      $stable(queue_count) |-> pad_clear(ae_bus, ae_word, queue_count));

endmodule

bind mq_flag_status_bus mqfs_chk #(
   .NUM_Q (NUM_Q),
   .BUS_W (BUS_W)
) u_chk (
   .wr_clk      (wr_clk),
   .wr_rst_n    (wr_rst_n),
   .rd_clk      (rd_clk),
   .rd_rst_n    (rd_rst_n),
   .direct_mode (direct_mode),
   .queue_count (queue_count),
   .af_addr     (af_addr),
   .af_addr_stb (af_addr_stb),
   .ae_addr     (ae_addr),
   .ae_addr_stb (ae_addr_stb),
   .af_bus      (af_bus),
   .af_word     (af_word),
   .ae_bus      (ae_bus),
   .ae_word     (ae_word)
);

// File: tb/sim_mq_flag_status_bus.sv
module sim_mq_flag_status_bus;

   logic        wr_clk = 1'b0;
   logic        rd_clk = 1'b0;
   logic        wr_rst_n = 1'b0;
   logic        rd_rst_n = 1'b0;
   logic        direct_mode = 1'b0;
   logic [5:0]  queue_count = 6'd32;
   logic [31:0] af_flags = '0;
   logic [1:0]  af_addr = '0;
   logic        af_addr_stb = 1'b0;
   logic [31:0] ae_flags = '0;
   logic [1:0]  ae_addr = '0;
   logic        ae_addr_stb = 1'b0;
   logic [7:0]  af_bus;
   logic [1:0]  af_word;
   logic [7:0]  ae_bus;
   logic [1:0]  ae_word;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   mq_flag_status_bus u0 (
      .wr_clk      (wr_clk),
      .wr_rst_n    (wr_rst_n),
      .rd_clk      (rd_clk),
      .rd_rst_n    (rd_rst_n),
      .direct_mode (direct_mode),
      .queue_count (queue_count),
      .af_flags    (af_flags),
      .af_addr     (af_addr),
      .af_addr_stb (af_addr_stb),
      .ae_flags    (ae_flags),
      .ae_addr     (ae_addr),
      .ae_addr_stb (ae_addr_stb),
      .af_bus      (af_bus),
      .af_word     (af_word),
      .ae_bus      (ae_bus),
      .ae_word     (ae_word)
   );

   // 100 MHz write clock; read clock of the same rate, rising 5 ns later
   always #5ns wr_clk = ~wr_clk;
   initial begin
      #5ns;
      forever #5ns rd_clk = ~rd_clk;
   end

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_bus(input logic [31:0] f, input int w, input int qc);
      logic [7:0] r;
      for (int j = 0; j < 8; j++) begin
         int q;
         q = w * 8 + j;
         r[j] = (q < qc) ? f[q] : 1'b0;
      end
      return r;
   endfunction

   function automatic int next_word(input int w, input bit dm, input bit stb, input int a);
      if (dm) return stb ? a : w;
      return (w + 1) % 4;
   endfunction

   function automatic string word_tag(input bit dm, input bit sw, input bit stb);
      if (!dm) return sw ? "R8" : "R3";
      return stb ? "R4" : "R5";
   endfunction

   task automatic run_phase(input bit dm, input int qc, input int iters,
                            input int switch_at, input bit directed);
      int mw;
      int me;
      bit cur;
      wr_rst_n = 1'b0;
      rd_rst_n = 1'b0;
      direct_mode = dm;
      queue_count = 6'(qc);
      af_flags = $urandom;
      ae_flags = $urandom;
      af_addr_stb = 1'b0;
      ae_addr_stb = 1'b0;
      af_addr = 2'd0;
      ae_addr = 2'd0;
      repeat (3) @(posedge wr_clk);
      #1ns;
      chk("R1 af reset", 16'({af_word, af_bus}), 16'h0);
      chk("R1 ae reset", 16'({ae_word, ae_bus}), 16'h0);
      wr_rst_n = 1'b1;
      rd_rst_n = 1'b1;
      mw = 0;
      me = 0;
      cur = dm;
      for (int i = 0; i < iters; i++) begin
         bit    sw;
         bit    sa;
         bit    se;
         int    aa;
         int    ea;
         string tw_af;
         string tw_ae;
         string tb_af;
         string tb_ae;
         sw = (i == switch_at);
         if (sw) begin
            cur = ~cur;
            direct_mode = cur;
         end
         af_flags = $urandom;
         ae_flags = $urandom;
         if (directed && i == 0) begin
            sa = 1'b1; aa = 2; se = 1'b0; ea = $urandom_range(0, 3);
         end else if (directed && i == 1) begin
            sa = 1'b0; aa = $urandom_range(0, 3); se = 1'b1; ea = 3;
         end else begin
            sa = 1'($urandom_range(0, 1));
            se = 1'($urandom_range(0, 1));
            aa = $urandom_range(0, 3);
            ea = $urandom_range(0, 3);
         end
         af_addr_stb = sa;
         ae_addr_stb = se;
         af_addr = 2'(aa);
         ae_addr = 2'(ea);
         mw = next_word(mw, cur, sa, aa);
         me = next_word(me, cur, se, ea);
         tw_af = word_tag(cur, sw, sa);
         tw_ae = word_tag(cur, sw, se);
         if (directed && i == 0) tw_ae = "R6";
         if (directed && i == 1) tw_af = "R6";
         tb_af = (qc < (mw + 1) * 8) ? "R7" : "R2";
         tb_ae = (qc < (me + 1) * 8) ? "R7" : "R2";
         @(posedge wr_clk);
         #1ns;
         chk({tw_af, " af word"}, 16'(af_word), 16'(mw));
         chk({tb_af, " af bus"},  16'(af_bus),  16'(exp_bus(af_flags, mw, qc)));
         chk({tw_ae, " ae word"}, 16'(ae_word), 16'(me));
         chk({tb_ae, " ae bus"},  16'(ae_bus),  16'(exp_bus(ae_flags, me, qc)));
      end
   endtask

   initial begin
      #1ms;
      if (!done) begin
         vectors++;
         miscompares++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd5151));
      run_phase(1'b0, 32, 150, -1, 1'b0);   // R2 R3 full configuration, polled
      run_phase(1'b1, 32, 150, -1, 1'b1);   // R4 R5 R6 direct
      run_phase(1'b0, 5,  80,  -1, 1'b0);   // R7 few queues, all words still polled
      run_phase(1'b1, 13, 150, -1, 1'b1);   // R7 partial second word, direct
      run_phase(1'b1, 20, 120, 60, 1'b0);   // R8 direct to polled
      run_phase(1'b0, 1,  60,  30, 1'b0);   // R7 single queue, polled to direct
      for (int k = 0; k < 4; k++) begin
         int  qc;
         bit  dm;
         int  sat;
         qc  = $urandom_range(1, 32);
         dm  = 1'($urandom_range(0, 1));
         sat = ($urandom_range(0, 1) == 1) ? 75 : -1;
         run_phase(dm, qc, 150, sat, 1'b0);
      end
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule